// File: doc/BRIEF.md
# Daisy-Chainable Serial Channel Programmer

This block is the write port of a twelve-channel, 10-bit level generator. A host writes 16-bit command words over three wires: an active-low frame select, a serial clock and serial data. All three are brought into the system clock domain through synchronizers, and the serial clock's edges are then found by comparing it with its previous sampled value. While the frame select is low, each rising serial clock edge shifts one bit into a 16-bit frame register, most significant bit first.

When the frame select returns high, the last 16 bits received are decoded into a channel number, a 10-bit level code and a refresh-clock source bit. The addressed channel register and the clock-source flag are then written. Frames that are too short, or that name a channel number that does not exist, leave everything unchanged. The top bit of the frame register is re-launched on falling serial clock edges as a chain output. Several devices can then share the select and clock lines, with each data output wired to the next device's data input. The first word shifted ends in the last device, and all devices commit together.

Top module: `serial_level_loader`

## Requirements
- R1: After reset every channel code is 0, the clock-source flag is 0 (internal refresh clock) and the chain output is 0.
- R2: While the frame select is low, each rising serial clock edge shifts the data input into the frame register, most significant bit first. The frame is laid out as follows: bit 15 is a test bit with no effect, bit 14 is the clock-source select, bits 13..10 are the binary channel number and bits 9..0 are the level code.
- R3: On the rising edge of the frame select, the addressed channel register takes the level code. Every other channel keeps its value.
- R4: The same commit loads the clock-source flag from bit 14 (1 = external, 0 = internal).
- R5: A frame whose channel number is 12 or above changes no channel code and does not change the clock-source flag.
- R6: A frame with fewer than 16 rising serial clock edges while the select is low is discarded. A frame with exactly 16 such edges commits.
- R7: A frame with more than 16 rising edges commits the last 16 bits shifted in.
- R8: Serial clock edges while the frame select is high shift nothing, commit nothing and leave the chain output unchanged.
- R9: The chain output changes only on falling serial clock edges while the frame is selected. It shows the bit that was shifted in 16 rising edges earlier, so a bit presented at the data input appears at the chain output on the 16th falling edge. In a two-device chain the first word of a 32-bit frame commits in the downstream device and the second word in the upstream device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sel_n | input | 1 | Active-low frame select, asynchronous to clk |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Chain data out, retimed on falling serial clock edges |
| ext_clk_mode | output | 1 | Refresh clock source flag, 1 = external |
| level_codes | output | NCH*10 | Stored code of each channel, channel 0 in the low bits |

## Verification
The bench builds the block with its default twelve channels and a two-stage synchronizer. It holds each serial clock phase for eight system cycles, so that data launched by the upstream device's retimed output settles before the downstream device samples it. Because the default channel count leaves four unused channel numbers in a 4-bit field, the discard path for out-of-range numbers can be reached. Two instances in a chain bring the word routing and the 16-edge output delay within reach of the port-level checks.

// File: rtl/lvlprog_pkg.sv
// Package: frame layout shared by the serial level loader and its checker.
// Assumes a fixed 16-bit command frame whose field positions are part of
// the host protocol.
package lvlprog_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 10;
    localparam int ADDR_W = 4;

    typedef struct packed {
        logic              test_bit;
        logic              ext_clk;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
    } cmd_t;
endpackage

// File: rtl/lvlprog_sync.sv
// Module: multi-bit level synchronizer.
// Each input bit passes through STAGES flops into the clk domain.
// Assumes the inputs are slow relative to clk; bits are synchronized
// independently.
module lvlprog_sync #(
    parameter int             N      = 3,
    parameter int             STAGES = 2,
    parameter logic [N-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        // Purpose: move one asynchronous bit through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{RST[b]}};
            else        pipe <= {pipe[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = pipe[STAGES-1];
    end
endmodule

// File: rtl/lvlprog_shifter.sv
// Module: serial frame receiver.
// Finds the serial clock and select edges, shifts bits in, counts rising
// edges per frame, retimes the chain output and raises a one-cycle commit
// when a frame of at least WORD_W bits closes.
// Assumes synchronized inputs and a serial clock that is low when the
// select falls.
module lvlprog_shifter
    import lvlprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl,
    input  logic              sclk_lvl,
    input  logic              sdi_lvl,
    output logic [WORD_W-1:0] word,
    output logic              sdo,
    output logic              commit,
    output logic              sclk_fall
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic             sclk_d, sel_d;
    logic             sclk_rise, sel_rise, sel_fall;
    logic [CNT_W-1:0] cnt;

    assign sclk_rise = sclk_lvl & ~sclk_d;
    assign sclk_fall = ~sclk_lvl & sclk_d;
    assign sel_rise  = sel_lvl & ~sel_d;
    assign sel_fall  = ~sel_lvl & sel_d;
    assign commit    = sel_rise && (cnt == FULL);

    // Purpose: keep the previous sampled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sel_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_lvl;
            sel_d  <= sel_lvl;
        end
    end

    // Purpose: count rising edges in the frame, saturating at WORD_W.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cnt <= '0;
        else if (sel_fall)                              cnt <= '0;
        else if (!sel_lvl && sclk_rise && cnt != FULL)  cnt <= cnt + 1'b1;
    end

    // Purpose: shift serial data in, MSB first, while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                     word <= '0;
        else if (!sel_lvl && sclk_rise) word <= {word[WORD_W-2:0], sdi_lvl};
    end

    // Purpose: re-launch the top frame bit on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sdo <= 1'b0;
        else if (!sel_lvl && sclk_fall) sdo <= word[WORD_W-1];
    end
endmodule

// File: rtl/lvlprog_regfile.sv
// Module: channel code store and clock-source flag.
// On commit, writes the code to the channel whose index matches addr and
// loads the mode bit; a number beyond the channel count writes nothing.
module lvlprog_regfile
    import lvlprog_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CODE_W-1:0]     code,
    input  logic                  ext_bit,
    output logic [NCH*CODE_W-1:0] codes,
    output logic                  ext_mode
);
    logic addr_ok;
    assign addr_ok = (32'(addr) < NCH);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Purpose: hold channel i's code, written only when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                codes[i*CODE_W +: CODE_W] <= '0;
            else if (commit && addr == ADDR_W'(i))
                codes[i*CODE_W +: CODE_W] <= code;
        end
    end

    // Purpose: latch the refresh clock source on a valid commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ext_mode <= 1'b0;
        else if (commit && addr_ok)  ext_mode <= ext_bit;
    end
endmodule

// File: rtl/serial_level_loader.sv
// Module: top of the daisy-chainable serial channel programmer.
// Synchronizes the three serial wires, receives frames and commits them
// into the channel store. Assumes the serial clock runs several times
// slower than clk.
module serial_level_loader
    import lvlprog_pkg::*;
#(
    parameter int NCH         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_sel_n,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    output logic                  ser_dout,
    output logic                  ext_clk_mode,
    output logic [NCH*CODE_W-1:0] level_codes
);
    logic [2:0] raw, lvl;
    logic       commit, sclk_fall;
    cmd_t       cmd;

    assign raw = {frame_sel_n, ser_clk, ser_din};

    lvlprog_sync #(.N(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(lvl)
    );

    lvlprog_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_lvl(lvl[2]), .sclk_lvl(lvl[1]), .sdi_lvl(lvl[0]),
        .word(cmd), .sdo(ser_dout), .commit(commit), .sclk_fall(sclk_fall)
    );

    lvlprog_regfile #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .addr(cmd.addr), .code(cmd.code), .ext_bit(cmd.ext_clk),
        .codes(level_codes), .ext_mode(ext_clk_mode)
    );
endmodule

// File: rtl/serial_level_loader_chk.sv
// Module: property checker bound into serial_level_loader.
// Observes commit, select level, frame word and outputs.
module serial_level_loader_chk
    import lvlprog_pkg::*;
#(
    parameter int NCH = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  commit,
    input logic                  sel_lvl,
    input logic                  sclk_fall,
    input cmd_t                  cmd,
    input logic                  sdo,
    input logic                  ext_mode,
    input logic [NCH*CODE_W-1:0] codes
);
    assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (codes != $past(codes)) |-> $past(commit));

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode != $past(ext_mode)) |-> $past(commit));

    assert_bad_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && 32'(cmd.addr) >= NCH) |=> ($stable(codes) && $stable(ext_mode)));

    assert_frame_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> sel_lvl);

    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> $stable(cmd));

    assert_sdo_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo != $past(sdo)) |-> ($past(sclk_fall) && !$past(sel_lvl)));
endmodule

bind serial_level_loader serial_level_loader_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sel_lvl(lvl[2]),
    .sclk_fall(sclk_fall), .cmd(cmd), .sdo(ser_dout),
    .ext_mode(ext_clk_mode), .codes(level_codes)
);

// File: tb/sim_serial_level_loader.sv
`timescale 1ns/1ps
module sim_serial_level_loader;
    localparam int NCH = 12;
    localparam int CW  = 10;
    localparam int H   = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic dout0, dout1, ext0, ext1;
    logic [NCH*CW-1:0] codes0, codes1;

    always #2.5 clk = ~clk;

    serial_level_loader #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_sel_n(sel_n), .ser_clk(sclk),
        .ser_din(sdi), .ser_dout(dout0), .ext_clk_mode(ext0), .level_codes(codes0)
    );
    serial_level_loader #(.NCH(NCH)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_sel_n(sel_n), .ser_clk(sclk),
        .ser_din(dout0), .ser_dout(dout1), .ext_clk_mode(ext1), .level_codes(codes1)
    );

    typedef struct packed {
        logic [NCH*CW-1:0] c0, c1;
        logic e0, e1, s0;
    } item_t;

    item_t q[$];
    string tags[$];
    event  ev;
    int    n_chk = 0, n_fail = 0;

    logic [NCH*CW-1:0] m_c0 = '0, m_c1 = '0;
    logic m_e0 = 1'b0, m_e1 = 1'b0, m_s0 = 1'b0;
    logic [15:0] sh0 = '0, sh1 = '0;

    task automatic check(string tag, string what, logic [NCH*CW-1:0] act, logic [NCH*CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(ev);
            repeat (10) @(posedge clk);
            #1;
            begin
                item_t it;
                string tg;
                it = q.pop_front();
                tg = tags.pop_front();
                check(tg, "codes u0", codes0, it.c0);
                check(tg, "codes u1", codes1, it.c1);
                check(tg, "mode u0", {{(NCH*CW-1){1'b0}}, ext0}, {{(NCH*CW-1){1'b0}}, it.e0});
                check(tg, "mode u1", {{(NCH*CW-1){1'b0}}, ext1}, {{(NCH*CW-1){1'b0}}, it.e1});
                check(tg, "chain out", {{(NCH*CW-1){1'b0}}, dout0}, {{(NCH*CW-1){1'b0}}, it.s0});
            end
        end
    end

    task automatic push(string tag);
        q.push_back('{c0: m_c0, c1: m_c1, e0: m_e0, e1: m_e1, s0: m_s0});
        tags.push_back(tag);
        -> ev;
        repeat (14) @(posedge clk);
    endtask

    task automatic apply(ref logic [NCH*CW-1:0] c, ref logic e, input logic [15:0] w);
        if (w[13:10] < NCH) begin
            c[w[13:10]*CW +: CW] = w[9:0];
            e = w[14];
        end
    endtask

    // Driver: sends n bits MSB first in one frame and models both devices.
    task automatic frame(input logic [63:0] bits, input int n, input string tag);
        sel_n = 1'b0;
        repeat (H) @(posedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            repeat (H) @(posedge clk);
            sh1 = {sh1[14:0], m_s0};
            sh0 = {sh0[14:0], bits[i]};
            sclk = 1'b1;
            repeat (H) @(posedge clk);
            sclk = 1'b0;
            m_s0 = sh0[15];
        end
        repeat (H) @(posedge clk);
        sel_n = 1'b1;
        if (n >= 16) begin
            apply(m_c0, m_e0, sh0);
            apply(m_c1, m_e1, sh1);
        end
        push(tag);
    endtask

    function automatic logic [15:0] w(logic ext, int ch, int code);
        return {1'b0, ext, 4'(ch), 10'(code)};
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        push("R1 reset");
        frame({48'h0, w(0, 0, 1023)}, 16, "R2 R3 ch0=1023");
        frame({48'h0, w(1, 11, 513)}, 16, "R4 ch11 external");
        frame({48'h0, w(0, 5, 31)}, 16, "R4 ch5 internal");
        frame({48'h0, w(1, 12, 77)}, 16, "R5 channel 12");
        frame({48'h0, w(1, 15, 900)}, 16, "R5 channel 15");
        frame({54'h0, 10'h2AB}, 10, "R6 10-bit frame");
        frame({49'h0, w(1, 3, 444)}, 15, "R6 15-bit frame");
        frame({44'h0, 4'hD, w(0, 7, 700)}, 20, "R7 20-bit frame");
        // Serial clock toggling with the frame deselected (R8).
        for (int i = 0; i < 20; i++) begin
            sdi = ~sdi;
            repeat (H) @(posedge clk);
            sclk = 1'b1;
            repeat (H) @(posedge clk);
            sclk = 1'b0;
        end
        push("R8 idle clocks");
        frame({32'h0, w(0, 2, 100), w(1, 9, 900)}, 32, "R9 chain");
        frame({48'h0, 16'h8001}, 16, "R2 test bit ignored");
        frame({32'h0, w(0, 4, 1), w(0, 8, 2)}, 32, "R9 chain second");
        repeat (20) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule